// File: doc/BRIEF.md
# Software Store/Recall Read-Sequence Detector

This block sits beside an asynchronous-style SRAM port whose strobes and address are sampled on a system clock. It watches ordinary read cycles and recognises a fixed, ordered chain of six reads from particular addresses. When the chain completes, it raises a one-cycle request towards the nonvolatile store/recall controller. There is no command register and no dedicated pin. The trigger is the chain of reads itself. A store chain and a recall chain share their first five addresses, and the last read decides which request is raised.

Any write, or any read from an address the chain does not expect, abandons a partial chain. A stray read that happens to hit the first chain address starts a new chain at step one. While the controller reports busy, the detector ignores the port completely and keeps its progress unchanged. The chain addresses are parameters. The memory array and the power sequencing are outside this block.

Top module: `sw_nv_seq_detect`

## Requirements
- R1: After a synchronous active-low reset, `store_req` and `recall_req` are low and no chain is in progress.
- R2: A read cycle is any sampled cycle with `ce_n`=0, `oe_n`=0 and `we_n`=1. A read is counted once, in the first sampled cycle in which `ce_n` or `oe_n` is high again, using the address sampled in the read's last active cycle. A read held for many cycles still counts once.
- R3: Six counted reads from `STORE_SEQ[0]` through `STORE_SEQ[5]` in that order raise `store_req` for exactly one cycle. The defaults are 0x0E38, 0x31C7, 0x03E0, 0x3C1F, 0x303F and 0x0FC0. The pulse is visible in the clock cycle after the edge that samples the end of the sixth read.
- R4: Counted reads from `STORE_SEQ[0]` through `STORE_SEQ[4]` followed by a read from `RECALL_LAST` (default 0x0C63) raise `recall_req` for exactly one cycle, with the same timing as R3. If `RECALL_LAST` equals `STORE_SEQ[5]`, the store request takes priority.
- R5: A counted read whose address is not the next expected one abandons the chain, and no request results from that chain.
- R6: A write cycle (`ce_n`=0 and `we_n`=0) abandons any partial chain. If a read end and a write are sampled in the same cycle, the write wins.
- R7: A counted read that mismatches the next expected address but equals `STORE_SEQ[0]` leaves the chain at step one, not at idle.
- R8: While `busy` is high, reads and writes are ignored and the chain progress is held. A read that is open while `busy` is high is never counted.
- R9: After either request, the chain returns to step zero. Repeating the sixth read alone raises no further request, but a full new chain does.
- R10: `store_req` and `recall_req` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | ADDR_W | Port address |
| busy | input | 1 | Store/recall in progress; ignore the port |
| store_req | output | 1 | One-cycle store request |
| recall_req | output | 1 | One-cycle recall request |

## Verification
The bench builds the block with its default parameters: a 15-bit address, a six-step chain and the default store and recall addresses. With these values the bench can drive real chain addresses and also stray ones. One stray address deliberately equals the first chain address, so the restart path of R7 is reachable. The bench also covers reads that end through the output enable while chip enable stays low, held reads, busy windows in the middle of a chain, and writes that coincide with a read end.

// File: rtl/nvseq_pkg.sv
// Package: shared types for the software store/recall sequence detector.
// Assumes nothing beyond the default address width below.
package nvseq_pkg;
    localparam int DEF_ADDR_W = 15;

    // One sampled port event handed from the tracker to the matcher
    typedef struct packed {
        logic rd_end;   // a read cycle has just finished
        logic wr;       // a write cycle is being sampled
    } port_ev_t;
endpackage

// File: rtl/nvseq_access_tracker.sv
// Access tracker: turns the sampled strobes into per-access events.
// A read counts once, when chip enable or output enable is released.
// The address is kept from the read's last active cycle.
// Assumes: strobes are already synchronous to clk. busy masks everything.
module nvseq_access_tracker
    import nvseq_pkg::*;
#(
    parameter int ADDR_W = DEF_ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              busy,
    output port_ev_t          ev,
    output logic [ADDR_W-1:0] rd_addr
);
    logic rd_now;
    logic rd_open_q;
    logic [ADDR_W-1:0] addr_q;

    // Classify the current sampled cycle
    always_comb begin
        rd_now    = !ce_n && !oe_n && we_n;
        ev.wr     = !busy && !ce_n && !we_n;
        ev.rd_end = !busy && rd_open_q && (ce_n || oe_n);
    end

    // Remember an open read and its latest address; busy drops it
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_open_q <= 1'b0;
            addr_q    <= '0;
        end else if (busy) begin
            rd_open_q <= 1'b0;
        end else begin
            rd_open_q <= rd_now;
            if (rd_now) addr_q <= addr;
        end
    end

    assign rd_addr = addr_q;

    // R2
    read_counted_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev.rd_end |=> !ev.rd_end);
endmodule

// File: rtl/nvseq_addr_compare.sv
// Address comparator bank: one hit flag per chain step, plus the recall tail.
// Assumes the chain addresses are constants fixed at elaboration.
module nvseq_addr_compare #(
    parameter int ADDR_W  = 15,
    parameter int SEQ_LEN = 6,
    parameter logic [SEQ_LEN-1:0][ADDR_W-1:0] STORE_SEQ = '0,
    parameter logic [ADDR_W-1:0] RECALL_LAST = '0
) (
    input  logic [ADDR_W-1:0]  rd_addr,
    output logic [SEQ_LEN-1:0] hit_seq,
    output logic               hit_recall
);
    // One equality comparator per chain position
    for (genvar i = 0; i < SEQ_LEN; i++) begin : g_hit
        assign hit_seq[i] = (rd_addr == STORE_SEQ[i]);
    end

    // Comparator for the alternative final address
    assign hit_recall = (rd_addr == RECALL_LAST);
endmodule

// File: rtl/nvseq_matcher.sv
// Chain matcher: a step counter advanced by counted reads.
// It drops back on a write or a mismatch, restarts at step one on a first-address hit,
// and pulses a request on a full chain.
// Assumes the events and the hit flags come from the same sampled cycle.
module nvseq_matcher
    import nvseq_pkg::*;
#(
    parameter int SEQ_LEN = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  port_ev_t           ev,
    input  logic [SEQ_LEN-1:0] hit_seq,
    input  logic               hit_recall,
    output logic               store_req,
    output logic               recall_req
);
    localparam int STEP_W = $clog2(SEQ_LEN);
    localparam int LAST   = SEQ_LEN - 1;
    localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(LAST);
    localparam logic [STEP_W-1:0] ONE_STEP  = STEP_W'(1);

    logic [STEP_W-1:0] step_q, step_d;
    logic              store_d, recall_d;

    // Next step and request decision for this sampled cycle
    always_comb begin
        step_d   = step_q;
        store_d  = 1'b0;
        recall_d = 1'b0;
        if (ev.wr) begin
            step_d = '0;
        end else if (ev.rd_end) begin
            if (step_q == LAST_STEP) begin
                if (hit_seq[LAST])   store_d  = 1'b1;
                else if (hit_recall) recall_d = 1'b1;
            end
            if (store_d || recall_d)                           step_d = '0;
            else if (step_q != LAST_STEP && hit_seq[step_q])   step_d = step_q + ONE_STEP;
            else if (hit_seq[0])                               step_d = ONE_STEP;
            else                                               step_d = '0;
        end
    end

    // Step and request registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step_q     <= '0;
            store_req  <= 1'b0;
            recall_req <= 1'b0;
        end else begin
            step_q     <= step_d;
            store_req  <= store_d;
            recall_req <= recall_d;
        end
    end

    // R6
    write_aborts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev.wr |=> step_q == '0);
    // R9
    idle_after_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (store_req || recall_req) |-> step_q == '0);
    // R3
    store_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        store_req |=> !store_req);
    // R4
    recall_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        recall_req |=> !recall_req);
    // R10
    req_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({store_req, recall_req}));
endmodule

// File: rtl/sw_nv_seq_detect.sv
// Top: software store/recall read-sequence detector.
// It joins the access tracker, the comparator bank and the chain matcher.
// Assumes the port strobes are synchronous to clk.
// busy is driven high by the controller for the whole store or recall.
module sw_nv_seq_detect
    import nvseq_pkg::*;
#(
    parameter int ADDR_W  = DEF_ADDR_W,
    parameter int SEQ_LEN = 6,
    parameter logic [SEQ_LEN-1:0][ADDR_W-1:0] STORE_SEQ =
        {15'h0FC0, 15'h303F, 15'h3C1F, 15'h03E0, 15'h31C7, 15'h0E38},
    parameter logic [ADDR_W-1:0] RECALL_LAST = 15'h0C63
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              busy,
    output logic              store_req,
    output logic              recall_req
);
    port_ev_t           ev;
    logic [ADDR_W-1:0]  rd_addr;
    logic [SEQ_LEN-1:0] hit_seq;
    logic               hit_recall;

    nvseq_access_tracker #(.ADDR_W(ADDR_W)) u_track (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .addr(addr), .busy(busy), .ev(ev), .rd_addr(rd_addr)
    );

    nvseq_addr_compare #(
        .ADDR_W(ADDR_W), .SEQ_LEN(SEQ_LEN),
        .STORE_SEQ(STORE_SEQ), .RECALL_LAST(RECALL_LAST)
    ) u_cmp (
        .rd_addr(rd_addr), .hit_seq(hit_seq), .hit_recall(hit_recall)
    );

    nvseq_matcher #(.SEQ_LEN(SEQ_LEN)) u_match (
        .clk(clk), .rst_n(rst_n), .ev(ev), .hit_seq(hit_seq),
        .hit_recall(hit_recall), .store_req(store_req), .recall_req(recall_req)
    );

    // R8
    busy_blocks_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !(store_req || recall_req));
endmodule

// File: tb/tb_sw_nv_seq_detect.sv
module tb_sw_nv_seq_detect;
    localparam int AW = 15;
    localparam int CLK_HALF = 10;   // 50 MHz

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, busy = 1'b0;
    logic [AW-1:0] addr = '0;
    logic store_req, recall_req;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;
    string cur_req = "R1";

    // chain addresses as the requirements state them
    int seq_a[6] = '{'h0E38, 'h31C7, 'h03E0, 'h3C1F, 'h303F, 'h0FC0};
    int rec_last = 'h0C63;

    sw_nv_seq_detect dut (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .addr(addr), .busy(busy), .store_req(store_req), .recall_req(recall_req)
    );

    always #CLK_HALF clk = ~clk;

    // behavioural reference: history queue of accepted chain addresses
    int  hist[$];
    bit  open_rd = 0;
    int  open_addr = 0;
    bit  exp_st = 0, exp_rc = 0;

    task automatic feed(input int a);
        int n;
        bit good;
        hist.push_back(a);
        n = hist.size();
        good = 1;
        if (n < 6) good = (a == seq_a[n-1]);
        else good = (a == seq_a[5]) || (a == rec_last);
        if (!good) begin
            hist.delete();
            if (a == seq_a[0]) hist.push_back(a);
        end else if (n == 6) begin
            if (a == seq_a[5]) exp_st = 1; else exp_rc = 1;
            hist.delete();
        end
    endtask

    always @(posedge clk) begin
        exp_st = 0;
        exp_rc = 0;
        if (!rst_n) begin
            hist.delete();
            open_rd = 0;
        end else if (busy) begin
            open_rd = 0;
        end else begin
            if (!ce_n && !we_n) hist.delete();
            else if (open_rd && (ce_n || oe_n)) feed(open_addr);
            open_rd = !ce_n && !oe_n && we_n;
            if (open_rd) open_addr = int'(addr);
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model, plus pulse counters
    int st_cnt = 0, rc_cnt = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            check(store_req == exp_st, cur_req, int'(store_req), int'(exp_st));
            check(recall_req == exp_rc, cur_req, int'(recall_req), int'(exp_rc));
            if (store_req) st_cnt++;
            if (recall_req) rc_cnt++;
        end
    end

    // read of given address, held for hold cycles; via_oe ends it with oe_n only
    task automatic rd(input int a, input int hold = 1, input bit via_oe = 0);
        @(negedge clk);
        addr = AW'(a); ce_n = 0; oe_n = 0; we_n = 1;
        repeat (hold - 1) @(negedge clk);
        @(negedge clk);
        oe_n = 1;
        if (!via_oe) ce_n = 1;
        @(negedge clk);
        ce_n = 1;
    endtask

    task automatic wr(input int a);
        @(negedge clk);
        addr = AW'(a); ce_n = 0; oe_n = 1; we_n = 0;
        @(negedge clk);
        ce_n = 1; we_n = 1;
    endtask

    task automatic chain(input int last);
        for (int i = 0; i < 5; i++) rd(seq_a[i]);
        rd(last);
    endtask

    task automatic begin_case(input string tag);
        cur_req = tag;
        repeat (3) @(negedge clk);
        st_cnt = 0;
        rc_cnt = 0;
    endtask

    task automatic end_case(input int est, input int erc);
        repeat (3) @(negedge clk);
        check(st_cnt == est, {cur_req, " store count"}, st_cnt, est);
        check(rc_cnt == erc, {cur_req, " recall count"}, rc_cnt, erc);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: outputs low in reset
        check(store_req == 0 && recall_req == 0, "R1 reset", int'(store_req | recall_req), 0);
        rst_n = 1;

        begin_case("R3");           // plain store chain
        chain(seq_a[5]);
        end_case(1, 0);

        begin_case("R4");           // recall chain
        chain(rec_last);
        end_case(0, 1);

        begin_case("R2");           // held reads and reads closed by oe_n
        rd(seq_a[0], 5); rd(seq_a[1], 1, 1); rd(seq_a[2], 7, 1);
        rd(seq_a[3]); rd(seq_a[4], 3); rd(seq_a[5], 4, 1);
        end_case(1, 0);

        begin_case("R5");           // stray address in the middle
        rd(seq_a[0]); rd(seq_a[1]); rd(seq_a[2]); rd('h1234);
        rd(seq_a[3]); rd(seq_a[4]); rd(seq_a[5]);
        end_case(0, 0);

        begin_case("R6");           // write in the middle
        rd(seq_a[0]); rd(seq_a[1]); rd(seq_a[2]); wr(seq_a[3]);
        rd(seq_a[3]); rd(seq_a[4]); rd(seq_a[5]);
        end_case(0, 0);

        begin_case("R6 coincident"); // write sampled with read end
        rd(seq_a[0]); rd(seq_a[1]); rd(seq_a[2]); rd(seq_a[3]); rd(seq_a[4]);
        @(negedge clk); addr = AW'(seq_a[5]); ce_n = 0; oe_n = 0; we_n = 1;
        @(negedge clk); oe_n = 1; we_n = 0;
        @(negedge clk); ce_n = 1; we_n = 1;
        end_case(0, 0);

        begin_case("R7");           // mismatch equal to first address restarts
        rd(seq_a[0]); rd(seq_a[1]); rd(seq_a[2]); rd(seq_a[0]);
        rd(seq_a[1]); rd(seq_a[2]); rd(seq_a[3]); rd(seq_a[4]); rd(seq_a[5]);
        end_case(1, 0);

        begin_case("R8");           // busy window in the middle of a chain
        rd(seq_a[0]); rd(seq_a[1]); rd(seq_a[2]);
        @(negedge clk); busy = 1;
        wr('h0); rd('h2222); rd(seq_a[5]);
        @(negedge clk); addr = AW'(seq_a[3]); ce_n = 0; oe_n = 0;
        @(negedge clk); busy = 0; ce_n = 1; oe_n = 1;   // read open in busy: not counted
        rd(seq_a[3]); rd(seq_a[4]); rd(seq_a[5]);
        end_case(1, 0);

        begin_case("R9");           // no retrigger from the last read alone
        chain(seq_a[5]); rd(seq_a[5]); rd(rec_last);
        chain(seq_a[5]);
        end_case(2, 0);

        begin_case("R10");          // back-to-back store then recall
        chain(seq_a[5]); chain(rec_last);
        end_case(1, 1);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(2 * CLK_HALF * 100000);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule